// File: doc/BRIEF.md
# Clause 22 MDIO Management Master with Register Port

This block lets software reach the management registers of external Ethernet PHYs. It is a slave on a simple 32-bit register bus with two word registers: a control word and a write-data word. Software places a PHY address and a PHY register address into the control word together with one of two start bits. The block then sends a complete clause 22 management frame on the MDC/MDIO pins and clears the start bit when the frame has finished.

The start bits also act as busy flags, so software polls the same word it wrote. A read start bit returns the 16-bit value shifted in from the PHY in the low half of that control word once it self-clears. A write start bit sends the low 16 bits of the write-data word, which software loads beforehand. MDC is a divided copy of the system clock and stays low between frames. MDIO is brought out as a separate input, output and output-enable, which the pad ring joins into one tristate pin.

Top module: `mdio_master_regs`

## Requirements
- R1: The control word is at byte address 0 and the write-data word at byte address 4. Reading address 4 returns the last value written there in bits 15:0 and zero in bits 31:16. Any other address reads as zero and ignores writes.
- R2: Writing control bit 27 while the block is idle starts a write frame. Bit 27 reads back as 1 for the whole frame and returns to 0 once the frame has ended.
- R3: Writing control bit 26 while idle starts a read frame. Bit 26 reads 1 until the frame has ended. It then reads 0, and bits 15:0 hold the 16 bits received from the PHY, first bit received in bit 15.
- R4: Control bits 25:21 carry the PHY register address and bits 20:16 the PHY address. Both read back as written and both appear in the frame.
- R5: A frame is 64 bits, sent MSB first on MDIO with one bit per MDC period. It consists of 32 ones, the start pattern 01, opcode 01 (write) or 10 (read), 5 PHY address bits, 5 register address bits, 2 turnaround bits and 16 data bits.
- R6: In a read frame MDIO is driven (output-enable 1) for the first 46 bits and released for the 2 turnaround bits and the 16 data bits. Incoming bits are sampled at the rising edge of MDC.
- R7: In a write frame MDIO is driven for all 64 bits. The turnaround is 10, and the data bits are the low 16 bits of the write-data word.
- R8: During a frame, MDC stays high for exactly MDC_HALF system clocks and low for exactly MDC_HALF system clocks. Between frames MDC is low.
- R9: A write to the control word while bit 26 or 27 is set is ignored. It starts no frame and does not change the address fields.
- R10: If bits 26 and 27 are both set in one accepted write, a read frame (opcode 10) is started and bit 27 stays 0.
- R11: While a frame is in progress, bits 15:0 of the control word keep the value they had before the frame started.
- R12: Outside a frame the MDIO output-enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_i | input | 1 | MDIO level seen at the pad |
| mdio_o | output | 1 | MDIO level to drive |
| mdio_oe | output | 1 | MDIO pad drive enable |

## Verification
The bench runs a PHY model that records every bit at MDC rising edges and returns a chosen 16-bit word during reads. It compares whole frames, turnaround values and drive-enable patterns against frames it builds itself. Several corner cases are directed:
- A control write during a frame. A design that accepts it corrupts the address fields or sends a second frame.
- Both start bits set in one write. A design that picks the wrong one sends opcode 01.
- A readback in the middle of a frame. A design that updates the data field early exposes partial shift data.
- The MDC high and low times are measured. An off-by-one in the divider gives periods of MDC_HALF±1.

// File: rtl/mdio_pkg.sv
// Package: shared constants, opcode type and frame builder for the
// MDIO management master. Assumes clause 22 frames of 64 bits.
package mdio_pkg;

    localparam int FRAME_BITS = 64;
    localparam int TA_IDX     = 46;   // first turnaround bit
    localparam int DATA_IDX   = 48;   // first data bit
    localparam int LAST_IDX   = FRAME_BITS - 1;

    localparam int CTRL_WR_BIT = 27;
    localparam int CTRL_RD_BIT = 26;
    localparam int CTRL_REG_LSB = 21;
    localparam int CTRL_PHY_LSB = 16;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10
    } mdio_op_e;

    // Assemble the full frame, first transmitted bit in bit 63.
    function automatic logic [FRAME_BITS-1:0] build_frame(
        input mdio_op_e     op,
        input logic [4:0]   phy,
        input logic [4:0]   regad,
        input logic [15:0]  wdata
    );
        logic [1:0] ta;
        ta = (op == OP_WRITE) ? 2'b10 : 2'b11;
        return {32'hFFFF_FFFF, 2'b01, op, phy, regad, ta, wdata};
    endfunction

endpackage

// File: rtl/mdio_clk_div.sv
// Module: MDC generator. While en is high it toggles mdc every HALF
// system clocks and flags the clock edge on which mdc rises or falls.
// While en is low the counter is cleared and mdc is held low.
// Assumes HALF >= 1.
module mdio_clk_div #(
    parameter int HALF = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic mdc,
    output logic rise_tick,
    output logic fall_tick
);
    localparam int CNT_W = $clog2(HALF + 1);
    localparam logic [CNT_W-1:0] TERM = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt;
    logic             mdc_q;
    logic             term;

    assign term      = en && (cnt == TERM);
    assign rise_tick = term && !mdc_q;
    assign fall_tick = term && mdc_q;
    assign mdc       = mdc_q;

    // Count system clocks inside each MDC phase and toggle at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            mdc_q <= 1'b0;
        end else if (!en) begin
            cnt   <= '0;
            mdc_q <= 1'b0;
        end else if (term) begin
            cnt   <= '0;
            mdc_q <= ~mdc_q;
        end else begin
            cnt   <= cnt + 1'b1;
        end
    end

    // R8: no frame, no clock
    a_r8_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !mdc_q);

    // R8: mdc only moves at the end of a phase
    a_r8_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !term) |=> $stable(mdc_q));

endmodule

// File: rtl/mdio_frame_engine.sv
// Module: serializer/deserializer for one management frame. A start
// pulse loads the 64-bit frame. The current bit is presented on mdio_o
// until MDC falls, and read data is shifted in at MDC rising edges.
// A done pulse follows the final falling edge. Assumes start only
// arrives while idle.
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  mdio_op_e    op,
    input  logic [4:0]  phy,
    input  logic [4:0]  regad,
    input  logic [15:0] wdata,
    input  logic        rise_tick,
    input  logic        fall_tick,
    input  logic        mdio_i,
    output logic        active,
    output logic        done,
    output logic [15:0] rdata,
    output logic        mdio_o,
    output logic        mdio_oe
);
    localparam logic [5:0] IDX_LAST = 6'(LAST_IDX);
    localparam logic [5:0] IDX_TA   = 6'(TA_IDX);
    localparam logic [5:0] IDX_DATA = 6'(DATA_IDX);

    logic                  active_q;
    logic                  is_read;
    logic [5:0]            idx;
    logic [FRAME_BITS-1:0] shreg;
    logic [15:0]           rdata_q;
    logic                  done_q;

    assign active  = active_q;
    assign done    = done_q;
    assign rdata   = rdata_q;
    assign mdio_o  = shreg[FRAME_BITS-1];
    assign mdio_oe = active_q && !(is_read && (idx >= IDX_TA));

    // Load, shift out, sample in and end the frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            is_read  <= 1'b0;
            idx      <= '0;
            shreg    <= '0;
            rdata_q  <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (start && !active_q) begin
                active_q <= 1'b1;
                is_read  <= (op == OP_READ);
                idx      <= '0;
                shreg    <= build_frame(op, phy, regad, wdata);
            end else if (active_q) begin
                if (rise_tick && is_read && (idx >= IDX_DATA))
                    rdata_q <= {rdata_q[14:0], mdio_i};
                if (fall_tick) begin
                    if (idx == IDX_LAST) begin
                        active_q <= 1'b0;
                        done_q   <= 1'b1;
                    end else begin
                        idx   <= idx + 1'b1;
                        shreg <= {shreg[FRAME_BITS-2:0], 1'b0};
                    end
                end
            end
        end
    end

    // R5: one bit per MDC period, in order
    a_r5_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && fall_tick && idx != IDX_LAST) |=> (idx == $past(idx) + 6'd1));

    // R3: done comes only as the frame ends
    a_r3_done_ends_frame: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!active_q && $past(active_q)));

endmodule

// File: rtl/mdio_ctrl_regs.sv
// Module: register port. Decodes the control and write-data words,
// accepts a start only while idle (read beats write), holds busy until
// the engine reports done, and latches read data at that moment.
// Assumes one bus write per asserted bus_we cycle.
module mdio_ctrl_regs
    import mdio_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              done,
    input  logic [15:0]       rd_result,
    output logic              start,
    output mdio_op_e          start_op,
    output logic [4:0]        start_phy,
    output logic [4:0]        start_reg,
    output logic [15:0]       wdata16,
    output logic              busy
);
    localparam logic [ADDR_W-1:0] ADDR_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] ADDR_WDAT = ADDR_W'(4);

    logic        wr_busy, rd_busy;
    logic [4:0]  regad_q, phy_q;
    logic [15:0] data_q, wdata_q;
    logic        hit_ctrl, hit_wdat, ctrl_accept, want_rd, want_wr;
    logic        unused_hi_bits;

    assign unused_hi_bits = ^bus_wdata[31:28];

    assign hit_ctrl    = (bus_addr == ADDR_CTRL);
    assign hit_wdat    = (bus_addr == ADDR_WDAT);
    assign busy        = wr_busy || rd_busy;
    assign ctrl_accept = bus_we && hit_ctrl && !busy;
    assign want_rd     = bus_wdata[CTRL_RD_BIT];
    assign want_wr     = bus_wdata[CTRL_WR_BIT];

    assign start     = ctrl_accept && (want_rd || want_wr);
    assign start_op  = want_rd ? OP_READ : OP_WRITE;
    assign start_phy = bus_wdata[CTRL_PHY_LSB +: 5];
    assign start_reg = bus_wdata[CTRL_REG_LSB +: 5];
    assign wdata16   = wdata_q;

    // Control word: fields, busy flags and captured read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_busy <= 1'b0;
            rd_busy <= 1'b0;
            regad_q <= '0;
            phy_q   <= '0;
            data_q  <= '0;
        end else if (ctrl_accept) begin
            regad_q <= start_reg;
            phy_q   <= start_phy;
            rd_busy <= want_rd;
            wr_busy <= want_wr && !want_rd;
        end else if (done) begin
            if (rd_busy)
                data_q <= rd_result;
            rd_busy <= 1'b0;
            wr_busy <= 1'b0;
        end
    end

    // Write-data word: software may load it at any time.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wdata_q <= '0;
        else if (bus_we && hit_wdat)
            wdata_q <= bus_wdata[15:0];
    end

    // Read mux for the two words.
    always_comb begin
        if (hit_ctrl)
            bus_rdata = {4'b0, wr_busy, rd_busy, regad_q, phy_q, data_q};
        else if (hit_wdat)
            bus_rdata = {16'b0, wdata_q};
        else
            bus_rdata = '0;
    end

    // R2: write busy holds until the engine finishes
    a_r2_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_busy && !done) |=> wr_busy);

    // R10: never both flags
    a_r10_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_busy, rd_busy}));

    // R11: data field frozen during a frame
    a_r11_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(data_q));

    // R9: fields untouched while busy
    a_r9_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(phy_q) && $stable(regad_q)));

endmodule

// File: rtl/mdio_master_regs.sv
// Module: top of the MDIO management master. Joins the register port,
// the frame engine and the MDC divider. MDC_HALF is the number of
// system clocks per MDC half period; choose it so MDC <= 2.5 MHz
// (40 at a 200 MHz system clock).
module mdio_master_regs
    import mdio_pkg::*;
#(
    parameter int MDC_HALF = 40,
    parameter int ADDR_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe
);
    logic        start, busy, active, done, rise_tick, fall_tick;
    mdio_op_e    start_op;
    logic [4:0]  start_phy, start_reg;
    logic [15:0] wdata16, rd_result;

    mdio_ctrl_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .done      (done),
        .rd_result (rd_result),
        .start     (start),
        .start_op  (start_op),
        .start_phy (start_phy),
        .start_reg (start_reg),
        .wdata16   (wdata16),
        .busy      (busy)
    );

    mdio_frame_engine u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op        (start_op),
        .phy       (start_phy),
        .regad     (start_reg),
        .wdata     (wdata16),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick),
        .mdio_i    (mdio_i),
        .active    (active),
        .done      (done),
        .rdata     (rd_result),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe)
    );

    mdio_clk_div #(.HALF(MDC_HALF)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (active),
        .mdc       (mdc),
        .rise_tick (rise_tick),
        .fall_tick (fall_tick)
    );

    // R12: pad is driven only while the register port shows busy
    a_r12_oe_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> busy);

endmodule

// File: tb/sim_mdio_master_regs.sv
`timescale 1ns/1ps
module sim_mdio_master_regs;
    localparam int HALF = 5;
    localparam real TCK = 5.0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_data = '0;
    logic [15:0] phy_val = '0;
    logic [63:0] seen_bits, seen_oe;
    int bitpos = 64;
    int frames = 0;
    int bad_phase = 0;
    realtime t_rise = 0.0, t_fall = 0.0;

    always #2.5 clk = ~clk;

    mdio_master_regs #(.MDC_HALF(HALF), .ADDR_W(3)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
    );

    // PHY model: record each bit at MDC rise, measure the phases
    always @(posedge mdc) begin
        if (bitpos > 0 && bitpos < 64 && ($realtime - t_fall) != HALF * TCK)
            bad_phase++;
        t_rise = $realtime;
        if (bitpos < 64) begin
            seen_bits[63 - bitpos] = mdio_o;
            seen_oe[63 - bitpos]   = mdio_oe;
            bitpos++;
            if (bitpos == 64) frames++;
        end
    end

    // PHY model: present read data after MDC falls
    always @(negedge mdc) begin
        if (($realtime - t_rise) != HALF * TCK) bad_phase++;
        t_fall = $realtime;
        mdio_i = (bitpos >= 48 && bitpos < 64) ? phy_val[63 - bitpos] : 1'b1;
    end

    function automatic logic [63:0] exp_frame(input logic [1:0] op, input logic [4:0] phy,
                                              input logic [4:0] rg, input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b01, op, phy, rg, (op == 2'b01) ? 2'b10 : 2'b11, d};
    endfunction

    function automatic logic [31:0] ctrl_word(input logic wr, input logic rd,
                                              input logic [4:0] phy, input logic [4:0] rg);
        return {4'b0, wr, rd, rg, phy, 16'h0};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] r;
        for (int i = 0; i < 5000; i++) begin
            bus_read(3'd0, r);
            if (r[27:26] == 2'b00) return;
        end
    endtask

    task automatic do_write(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] d);
        logic [31:0] r;
        logic [63:0] e;
        bus_write(3'd4, {16'hA5A5, d});
        bitpos = 0;
        bus_write(3'd0, ctrl_word(1'b1, 1'b0, phy, rg));
        bus_read(3'd0, r);
        check(r[27:26] == 2'b10, "R2 busy during write", r, 32'h0800_0000);
        check(r[15:0] == exp_data, "R11 data frozen mid write", r[15:0], exp_data);
        wait_idle();
        e = exp_frame(2'b01, phy, rg, d);
        check(seen_bits == e, "R5 R7 write frame", seen_bits, e);
        check(seen_oe == 64'hFFFF_FFFF_FFFF_FFFF, "R7 drive all bits", seen_oe, 64'hFFFF_FFFF_FFFF_FFFF);
        bus_read(3'd0, r);
        check(r == {6'b0, rg, phy, exp_data}, "R2 R4 ctrl after write", r, {6'b0, rg, phy, exp_data});
    endtask

    task automatic do_read(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] v,
                           input logic both);
        logic [31:0] r;
        logic [63:0] e;
        phy_val = v;
        bitpos = 0;
        bus_write(3'd0, ctrl_word(both, 1'b1, phy, rg));
        bus_read(3'd0, r);
        check(r[27:26] == 2'b01, "R3 R10 read busy only", r, 32'h0400_0000);
        check(r[15:0] == exp_data, "R11 data frozen mid read", r[15:0], exp_data);
        wait_idle();
        e = exp_frame(2'b10, phy, rg, 16'h0);
        check(seen_bits[63:18] == e[63:18], "R5 R10 read frame head", seen_bits, e);
        check(seen_oe == {46'h3FFF_FFFF_FFFF, 18'h0}, "R6 release from turnaround",
              seen_oe, {46'h3FFF_FFFF_FFFF, 18'h0});
        exp_data = v;
        bus_read(3'd0, r);
        check(r == {6'b0, rg, phy, v}, "R3 R4 read result", r, {6'b0, rg, phy, v});
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int f0;
        void'($urandom(32'd4711));
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // reset state
        bus_read(3'd0, r);
        check(r == 32'h0, "R1 ctrl reset", r, 0);
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R8 R12 idle pins", {mdc, mdio_oe}, 0);

        // R1 map
        bus_write(3'd4, 32'hDEAD_1234);
        bus_read(3'd4, r);
        check(r == 32'h0000_1234, "R1 wdata readback", r, 32'h1234);
        bus_write(3'd2, 32'h0800_0000);
        bus_read(3'd2, r);
        check(r == 32'h0 && mdio_oe == 1'b0, "R1 unmapped ignored", r, 0);
        bus_read(3'd0, r);
        check(r == 32'h0, "R1 ctrl untouched by unmapped", r, 0);

        // directed frames
        do_write(5'd1, 5'd0, 16'h8000);
        do_read(5'd31, 5'd31, 16'hFFFF, 1'b0);
        do_read(5'd0, 5'd1, 16'h0001, 1'b1);   // R10 both bits

        // R9 write during busy is ignored
        f0 = frames;
        phy_val = 16'h5A3C;
        bitpos = 0;
        bus_write(3'd0, ctrl_word(1'b0, 1'b1, 5'd3, 5'd7));
        bus_write(3'd0, ctrl_word(1'b1, 1'b0, 5'd20, 5'd9));
        bus_read(3'd0, r);
        check(r[27:16] == {2'b01, 5'd7, 5'd3}, "R9 fields kept while busy", r[27:16], {2'b01, 5'd7, 5'd3});
        wait_idle();
        exp_data = 16'h5A3C;
        repeat (4 * HALF) @(negedge clk);
        check(frames == f0 + 1, "R9 no extra frame", frames, f0 + 1);
        bus_read(3'd0, r);
        check(r == {6'b0, 5'd7, 5'd3, 16'h5A3C}, "R9 R3 ctrl after ignored write", r, {6'b0, 5'd7, 5'd3, 16'h5A3C});
        check(mdc == 1'b0 && mdio_oe == 1'b0, "R8 R12 idle after frame", {mdc, mdio_oe}, 0);

        // random mix
        for (int i = 0; i < 10; i++) begin
            logic [4:0] p, g;
            logic [15:0] d;
            p = 5'($urandom); g = 5'($urandom); d = 16'($urandom);
            if ($urandom % 2 == 0) do_write(p, g, d);
            else do_read(p, g, d, 1'($urandom));
        end

        check(bad_phase == 0, "R8 MDC phase length", bad_phase, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule